// File: doc/BRIEF.md
# Asynchronous Memory Bank Strobe Timer

This block connects a simple request port to a single asynchronous static memory or NAND device. It turns each read or write request into chip-select, output-enable and write-enable waveforms. Each access runs through three programmable phases: setup, active strobe and hold. The phase lengths come from one 32-bit configuration word, and reads and writes have their own fields. When an access runs in the opposite direction to the one before it, a programmable idle gap is inserted first so the data bus can change direction.

NAND devices are also supported. Two request address bits drive the command-latch and address-latch lines for the length of the access. The device busy/ready pin is synchronised and presented as a status bit. A control bit tells an external ECC accumulator to run. One mode bit narrows chip-select to the strobe phase only. A second mode bit lets an external wait input stretch the strobe phase.

Top module: `async_bank_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x3FFFFFFC, so every timing field is at its maximum. Chip-select, output-enable and write-enable are high (inactive), reqReady is high and eccEn is low. A request accepted with this word takes 16 setup, 64 strobe and 8 hold cycles. The word is reloaded by pulsing cfgWrEn with cfgWrData.
- R2: A read runs read-setup+1 cycles with memCsN low and memOeN high, then read-strobe+1 cycles with memOeN low, then read-hold+1 cycles with memCsN low and memOeN high. Read setup is bits 16:13, read strobe is bits 12:7 and read hold is bits 6:4. memWeN stays high for the whole read.
- R3: A write uses the fields at bits 29:26 (setup), 25:20 (strobe) and 19:17 (hold). memWeN is low only during its strobe phase. memDoe is high and memDout equals the request data from the first setup cycle to the last hold cycle.
- R4: For a read, memDin is sampled on the last strobe cycle. In the cycle after the last hold cycle, rspValid is high for one cycle with that value on rspRdata. Writes never raise rspValid.
- R5: With bit 31 set, memCsN is low only during the strobe phase. With bit 31 clear, memCsN is low from setup through hold.
- R6: With bit 30 set, each strobe cycle in which memWait is high adds one cycle to the strobe phase. With bit 30 clear, memWait has no effect on the phase lengths.
- R7: When a request's direction differs from the previous completed access, turnaround+1 idle cycles come before its setup phase, with all strobes high. Turnaround is bits 3:2. No gap is inserted between accesses in the same direction, or for the first access after reset.
- R8: memCle is high while request address bit 4 is set, and memAle while address bit 3 is set, both only from setup through hold. If both bits are set, only memCle is asserted.
- R9: statusReady follows the devRdy pin with a latency of two clock edges.
- R10: A pulse on eccStart sets eccEn and a pulse on eccClear clears it. If both arrive in the same cycle, the clear wins.
- R11: reqReady is high only while no access or turnaround is in progress. A request is accepted in a cycle where both reqValid and reqReady are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Load configuration word |
| cfgWrData | input | 32 | New configuration word |
| cfgWord | output | 32 | Current configuration word |
| eccStart | input | 1 | Set the ECC run bit |
| eccClear | input | 1 | Clear the ECC run bit |
| eccEn | output | 1 | ECC run bit |
| devRdy | input | 1 | Device ready pin (asynchronous) |
| statusReady | output | 1 | Synchronised ready status |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Block idle, request can be taken |
| rspValid | output | 1 | Read data valid pulse |
| rspRdata | output | DATA_W | Captured read data |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memAddr | output | ADDR_W | Address held for the access |
| memDout | output | DATA_W | Write data to device |
| memDoe | output | 1 | Data output enable |
| memDin | input | DATA_W | Read data from device |
| memWait | input | 1 | Strobe extension request |
| memCle | output | 1 | Command latch enable |
| memAle | output | 1 | Address latch enable |

## Verification
The bench starts with a read at the reset timing, which proves the maximum field lengths. It then reloads short timings and runs read/write sequences that both change direction and repeat it, so a turnaround gap that is missing, or inserted when it should not be, shows up at once. Addresses with the command bit, the address bit and both bits set tell the two latch lines apart and check the priority between them. Wait pulses are applied with the extension bit clear and with it set, and select-strobe mode is run against normal mode, to separate a stretched strobe from an ignored one and a narrowed chip-select from a full-width one.

// File: rtl/abc_pkg.sv
package abc_pkg;

  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // field layout of the 32-bit timing word, MSB first
  typedef struct packed {
    logic       selStrobe;
    logic       extWait;
    logic [3:0] wrSetup;
    logic [5:0] wrStrobe;
    logic [2:0] wrHold;
    logic [3:0] rdSetup;
    logic [5:0] rdStrobe;
    logic [2:0] rdHold;
    logic [1:0] turnGap;
    logic [1:0] busSize;
  } cfg_s;

  localparam logic [31:0] CFG_RESET = 32'h3FFF_FFFC;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic csOn;
    logic oeOn;
    logic weOn;
    logic driveOn;
    logic latchOn;
    logic capture;
    logic rdDone;
  } ctl_s;

endpackage

// File: rtl/abc_ctrl.sv
module abc_ctrl
  import abc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  cfg_s cfg,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic memWait,
  output logic reqReady,
  output ctl_s ctl
);

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic              curWrite;
  logic              prevWrite;
  logic              hasPrev;
  logic              stall;
  logic              lastCnt;

  function automatic logic [CNT_W-1:0] setupOf(cfg_s c, logic w);
    return w ? CNT_W'(c.wrSetup) : CNT_W'(c.rdSetup);
  endfunction

  function automatic logic [CNT_W-1:0] strobeOf(cfg_s c, logic w);
    return w ? CNT_W'(c.wrStrobe) : CNT_W'(c.rdStrobe);
  endfunction

  function automatic logic [CNT_W-1:0] holdOf(cfg_s c, logic w);
    return w ? CNT_W'(c.wrHold) : CNT_W'(c.rdHold);
  endfunction

  assign stall   = (phase == PH_STROBE) && cfg.extWait && memWait;
  assign lastCnt = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      curWrite  <= 1'b0;
      prevWrite <= 1'b0;
      hasPrev   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            curWrite <= reqWrite;
            if (hasPrev && (prevWrite != reqWrite)) begin
              phase <= PH_TURN;
              cnt   <= CNT_W'(cfg.turnGap);
            end else begin
              phase <= PH_SETUP;
              cnt   <= setupOf(cfg, reqWrite);
            end
          end
        end
        PH_TURN: begin
          if (lastCnt) begin
            phase <= PH_SETUP;
            cnt   <= setupOf(cfg, curWrite);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_SETUP: begin
          if (lastCnt) begin
            phase <= PH_STROBE;
            cnt   <= strobeOf(cfg, curWrite);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (!stall) begin
            if (lastCnt) begin
              phase <= PH_HOLD;
              cnt   <= holdOf(cfg, curWrite);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (lastCnt) begin
            phase     <= PH_IDLE;
            prevWrite <= curWrite;
            hasPrev   <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  logic busy;
  assign busy     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign reqReady = (phase == PH_IDLE);

  always_comb begin
    ctl         = '0;
    ctl.load    = reqReady && reqValid;
    ctl.csOn    = cfg.selStrobe ? (phase == PH_STROBE) : busy;
    ctl.oeOn    = (phase == PH_STROBE) && !curWrite;
    ctl.weOn    = (phase == PH_STROBE) && curWrite;
    ctl.driveOn = busy && curWrite;
    ctl.latchOn = busy;
    ctl.capture = (phase == PH_STROBE) && lastCnt && !stall && !curWrite;
    ctl.rdDone  = (phase == PH_HOLD) && lastCnt && !curWrite;
  end

endmodule

// File: rtl/abc_datapath.sv
module abc_datapath
  import abc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int CLE_BIT = 4,
  parameter int ALE_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memCle,
  output logic              memAle,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) rdataQ <= memDin;
      rspQ <= ctl.rdDone;
    end
  end

  logic cleBit, aleBit;
  assign cleBit = addrQ[CLE_BIT];
  assign aleBit = addrQ[ALE_BIT];

  assign memAddr  = addrQ;
  assign memDout  = wdataQ;
  assign memDoe   = ctl.driveOn;
  assign memCsN   = !ctl.csOn;
  assign memOeN   = !ctl.oeOn;
  assign memWeN   = !ctl.weOn;
  assign memCle   = ctl.latchOn && cleBit;
  assign memAle   = ctl.latchOn && aleBit && !cleBit;
  assign rspValid = rspQ;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/async_bank_ctrl.sv
module async_bank_ctrl
  import abc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CLE_BIT     = 4,
  parameter int ALE_BIT     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgWord,
  input  logic              eccStart,
  input  logic              eccClear,
  output logic              eccEn,
  input  logic              devRdy,
  output logic              statusReady,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  input  logic [DATA_W-1:0] memDin,
  input  logic              memWait,
  output logic              memCle,
  output logic              memAle
);

  logic [31:0]            cfgQ;
  logic                   eccQ;
  logic [SYNC_STAGES-1:0] rdySync;
  cfg_s                   cfg;
  ctl_s                   ctl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= CFG_RESET;
      eccQ <= 1'b0;
    end else begin
      if (cfgWrEn) cfgQ <= cfgWrData;
      if (eccClear)      eccQ <= 1'b0;
      else if (eccStart) eccQ <= 1'b1;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) rdySync[s] <= 1'b0;
        else       rdySync[s] <= (s == 0) ? devRdy : rdySync[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign cfg         = cfg_s'(cfgQ);
  assign cfgWord     = cfgQ;
  assign eccEn       = eccQ;
  assign statusReady = rdySync[SYNC_STAGES-1];

  abc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .memWait  (memWait),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  abc_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CLE_BIT (CLE_BIT),
    .ALE_BIT (ALE_BIT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .memDoe   (memDoe),
    .memCsN   (memCsN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memCle   (memCle),
    .memAle   (memAle),
    .rspValid (rspValid),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/abc_checker.sv
module abc_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] cfgWord,
  input logic        memCsN,
  input logic        memOeN,
  input logic        memWeN,
  input logic        memCle,
  input logic        memAle,
  input logic        memWait,
  input logic        rspValid,
  input logic        reqReady,
  input logic        devRdy,
  input logic        statusReady,
  input logic        eccClear,
  input logic        eccEn
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)               sinceRst <= 2'd0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  p_oe_we_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> !memCsN);

  p_latch_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(memCle && memAle));

  p_rsp_after_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!reqReady));

  p_wait_stretch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && memWait && cfgWord[30]) |=> !memOeN);

  p_ready_sync_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (statusReady == $past(devRdy, 2)));

  p_ecc_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(eccClear) |-> !eccEn);

endmodule

bind async_bank_ctrl abc_checker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWord     (cfgWord),
  .memCsN      (memCsN),
  .memOeN      (memOeN),
  .memWeN      (memWeN),
  .memCle      (memCle),
  .memAle      (memAle),
  .memWait     (memWait),
  .rspValid    (rspValid),
  .reqReady    (reqReady),
  .devRdy      (devRdy),
  .statusReady (statusReady),
  .eccClear    (eccClear),
  .eccEn       (eccEn)
);

// File: tb/async_bank_ctrl_tb.sv
module async_bank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgWord;
  logic        eccStart = 1'b0;
  logic        eccClear = 1'b0;
  logic        eccEn;
  logic        devRdy = 1'b0;
  logic        statusReady;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady;
  logic        rspValid;
  logic [7:0]  rspRdata;
  logic        memCsN, memOeN, memWeN, memDoe, memCle, memAle;
  logic [15:0] memAddr;
  logic [7:0]  memDout;
  logic [7:0]  memDin = '0;
  logic        memWait = 1'b0;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // bench copy of the timing fields
  int  mSel, mExt, mWsu, mWst, mWh, mRsu, mRst, mRh, mTa;
  bit  mHasPrev = 0;
  bit  mPrevWr = 0;

  always #2.5 clk = ~clk;

  async_bank_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgWord(cfgWord), .eccStart(eccStart), .eccClear(eccClear), .eccEn(eccEn),
    .devRdy(devRdy), .statusReady(statusReady), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspValid(rspValid), .rspRdata(rspRdata),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memDout(memDout), .memDoe(memDoe), .memDin(memDin), .memWait(memWait),
    .memCle(memCle), .memAle(memAle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pins(input string req, input bit cs, input bit oe, input bit we,
                      input bit doe, input bit cle, input bit ale, input bit rdy);
    chk({req, " csN"}, 32'(memCsN), 32'(cs));
    chk({req, " oeN"}, 32'(memOeN), 32'(oe));
    chk({req, " weN"}, 32'(memWeN), 32'(we));
    chk({req, " doe"}, 32'(memDoe), 32'(doe));
    chk({req, " cle"}, 32'(memCle), 32'(cle));
    chk({req, " ale"}, 32'(memAle), 32'(ale));
    chk({req, " reqReady R11"}, 32'(reqReady), 32'(rdy));
  endtask

  function automatic logic [31:0] mkCfg(int sel, int ext, int wsu, int wst, int wh,
                                        int rsu, int rst, int rh, int ta);
    return (32'(sel) << 31) | (32'(ext) << 30) | (32'(wsu) << 26) | (32'(wst) << 20) |
           (32'(wh) << 17) | (32'(rsu) << 13) | (32'(rst) << 7) | (32'(rh) << 4) |
           (32'(ta) << 2);
  endfunction

  task automatic setCfg(input int sel, input int ext, input int wsu, input int wst,
                        input int wh, input int rsu, input int rst, input int rh,
                        input int ta);
    cfgWrData = mkCfg(sel, ext, wsu, wst, wh, rsu, rst, rh, ta);
    cfgWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0;
    mSel = sel; mExt = ext; mWsu = wsu; mWst = wst; mWh = wh;
    mRsu = rsu; mRst = rst; mRh = rh; mTa = ta;
    chk("R1 cfg reload", cfgWord, mkCfg(sel, ext, wsu, wst, wh, rsu, rst, rh, ta));
  endtask

  // one access; called at a negedge with the block idle
  task automatic access(input bit wr, input logic [15:0] addr, input logic [7:0] data,
                        input int waits);
    bit turn, cle, ale;
    int su, st, hd, stTotal;
    turn = mHasPrev && (mPrevWr != wr);
    cle  = addr[4];
    ale  = addr[3] && !addr[4];
    su = wr ? mWsu : mRsu;
    st = wr ? mWst : mRst;
    hd = wr ? mWh  : mRh;
    stTotal = st + 1 + (mExt != 0 ? waits : 0);
    reqWrite = wr; reqAddr = addr; reqWdata = data; memDin = data;
    reqValid = 1'b1;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    reqAddr = 16'hFFFF;
    reqWdata = 8'h00;
    if (turn) begin
      for (int i = 0; i <= mTa; i++) begin
        pins("R7 turnaround", 1, 1, 1, 0, 0, 0, 0);
        @(negedge clk);
      end
    end
    for (int i = 0; i <= su; i++) begin
      pins(wr ? "R3 setup" : "R2 setup", (mSel != 0), 1, 1, wr, cle, ale, 0);
      if (wr) chk("R3 dout", 32'(memDout), 32'(data));
      @(negedge clk);
    end
    for (int i = 0; i < stTotal; i++) begin
      memWait = (i < waits);
      #1;
      pins(waits > 0 ? "R6 strobe" : (wr ? "R3 strobe" : "R2 strobe"),
           0, wr, !wr, wr, cle, ale, 0);
      @(negedge clk);
    end
    memWait = 1'b0;
    for (int i = 0; i <= hd; i++) begin
      pins(wr ? "R3 hold" : "R2 hold", (mSel != 0), 1, 1, wr, cle, ale, 0);
      @(negedge clk);
    end
    pins("R2 end idle", 1, 1, 1, 0, 0, 0, 1);
    chk("R4 rspValid", 32'(rspValid), 32'(!wr));
    if (!wr) chk("R4 rspRdata", 32'(rspRdata), 32'(data));
    memDin = 8'h00;
    mHasPrev = 1;
    mPrevWr = wr;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
          bad++;
          checks++;
          $display("FAIL watchdog: actual=hung expected=done");
          $display("test done: total=%0d bad=%0d", checks, bad);
          $finish;
        end
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg reset", cfgWord, 32'h3FFFFFFC);
    chk("R1 eccEn", 32'(eccEn), 0);
    pins("R1 reset", 1, 1, 1, 0, 0, 0, 1);
    mSel = 0; mExt = 0; mWsu = 15; mWst = 63; mWh = 7;
    mRsu = 15; mRst = 63; mRh = 7; mTa = 3;

    // R1 read at reset timing, command latch address
    access(0, 16'h0010, 8'hA5, 0);

    setCfg(0, 0, 0, 1, 1, 1, 2, 0, 2);
    access(1, 16'h0008, 8'h3C, 0);   // R7 turn, R8 ale
    access(1, 16'h0018, 8'h5A, 0);   // R7 no turn, R8 both bits -> cle
    access(0, 16'h0001, 8'hC3, 3);   // R6 wait ignored with ext clear
    access(0, 16'h0000, 8'h96, 0);   // same direction back to back

    setCfg(1, 1, 2, 0, 0, 0, 1, 2, 0);
    access(0, 16'h0010, 8'h77, 2);   // R5 select-strobe, R6 stretch
    access(1, 16'h0008, 8'h11, 1);   // R6 write stretch, R7 gap of one

    // R9 ready sync
    devRdy = 1'b1;
    @(negedge clk);
    chk("R9 one edge", 32'(statusReady), 0);
    @(negedge clk);
    chk("R9 two edges", 32'(statusReady), 1);
    devRdy = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 fall", 32'(statusReady), 0);

    // R10 ECC run bit
    eccStart = 1'b1;
    @(negedge clk);
    eccStart = 1'b0;
    chk("R10 set", 32'(eccEn), 1);
    eccStart = 1'b1; eccClear = 1'b1;
    @(negedge clk);
    eccStart = 1'b0; eccClear = 1'b0;
    chk("R10 clear wins", 32'(eccEn), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule